// File: doc/BRIEF.md
# Dual Alarm Matcher with Shared Interrupt / Square-Wave Pin

This block watches a BCD time of day and compares it against two programmable alarm sets each time the time advances. Alarm 1 holds seconds, minutes, hours and a day-or-date byte. Alarm 2 holds minutes, hours and a day-or-date byte, and it always requires second 00. Each byte carries a mask bit, and each field that is masked is left out of the comparison. This gives repeat rates such as every second, every minute, or a full match on a day or a date. A hit sets a sticky flag per alarm. Software can clear a flag only by writing a zero to it.

One active-low output pin serves two uses. In interrupt mode it is pulled low while any flag is set whose enable is on. In square-wave mode it carries a 50% duty wave. The wave is derived from a reference step input, at one of four rates. The time fields and the once-per-second strobe come from a calendar counter elsewhere. Configuration arrives through a simple write port with a 4-bit offset.

Top module: `dual_alarm_irq`

## Requirements
- R1: After reset both flags are 0 and the pin is high (released). The control state is interrupt mode with both interrupt enables off and rate select 11.
- R2: Alarm 1 uses offset 0 for seconds, 1 for minutes, 2 for hours and 3 for day/date. Bit 7 of each byte masks that field. On a strobe, alarm 1 hits when every unmasked field equals the time: bits 6:0 for seconds, minutes and hours, and bits 5:0 for day/date. With all four fields masked it hits on every strobe.
- R3: Alarm 2 uses offset 4 for minutes, 5 for hours and 6 for day/date, with the same bit-7 mask rule. It hits only when the current seconds equal 00. With all three fields masked it hits once per minute, at second 00.
- R4: Bit 6 of a day/date alarm byte picks the target. A 1 compares bits 5:0 with the day of week, and a 0 compares them with the date of the month.
- R5: Comparison happens only in a cycle where `sec_tick` is high. The resulting flag shows on `alm_flag` one clock later. A matching time with no strobe sets nothing.
- R6: Offset 8 holds the flags, with bit 0 for alarm 1 and bit 1 for alarm 2. Writing 0 to a bit clears that flag, and writing 1 leaves it unchanged. A flag stays set until it is cleared.
- R7: If a clear write and a new hit for the same alarm fall in one cycle, the flag ends up set.
- R8: A hit sets its flag whatever the pin mode and whatever the enable bits.
- R9: Offset 7 is control. Bit 2 is the pin mode (1 = interrupt), bit 1 enables alarm 2 and bit 0 enables alarm 1. In interrupt mode the pin is low exactly when a flag is set together with its enable.
- R10: In mode 0 the pin carries a 50% duty square wave. It advances only on cycles with `ref_tick` high. Control bits 4:3 set the half period in reference steps: 00 gives REF_HZ/2 steps (1 Hz), 01 gives REF_HZ/2048 (1.024 kHz), 10 gives REF_HZ/8192 (4.096 kHz) and 11 gives REF_HZ/16384 (8.192 kHz).
- R11: Every control write restarts the wave. The wave is high from the write edge for one full half period, then low for one half period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sec_tick | input | 1 | Once-per-second time update strobe |
| now_sec | input | 7 | Current seconds, BCD |
| now_min | input | 7 | Current minutes, BCD |
| now_hour | input | 7 | Current hours byte bits 6:0 (mode, AM/PM, BCD) |
| now_day | input | 3 | Current day of week |
| now_date | input | 6 | Current date of month, BCD |
| ref_tick | input | 1 | One reference step of the REF_HZ source |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register offset |
| wr_data | input | 8 | Register write data |
| alm_flag | output | 2 | Sticky flags, bit 0 alarm 1, bit 1 alarm 2 |
| irq_sqw_n | output | 1 | Active-low interrupt or square wave (high = released) |

## Verification
The bench builds the block with REF_HZ at its default of 32768, and it drives `ref_tick` high on every cycle. The 1 Hz setting then needs 16384 cycles per half period. That keeps all four rates within reach, including the slowest, and each half period is measured to the exact cycle. Keeping the reference at its real value means the divisors the bench checks are the ones a real source produces.

// File: rtl/dalm_pkg.sv
package dalm_pkg;

    localparam int unsigned NUM_ALM  = 2;
    localparam int unsigned ADDR_W   = 4;
    localparam int unsigned MASK_BIT = 7;
    localparam int unsigned DYDT_BIT = 6;

    localparam logic [ADDR_W-1:0] ADR_A1_SEC = 4'd0;
    localparam logic [ADDR_W-1:0] ADR_A1_MIN = 4'd1;
    localparam logic [ADDR_W-1:0] ADR_A1_HR  = 4'd2;
    localparam logic [ADDR_W-1:0] ADR_A1_DD  = 4'd3;
    localparam logic [ADDR_W-1:0] ADR_A2_MIN = 4'd4;
    localparam logic [ADDR_W-1:0] ADR_A2_HR  = 4'd5;
    localparam logic [ADDR_W-1:0] ADR_A2_DD  = 4'd6;
    localparam logic [ADDR_W-1:0] ADR_CTRL   = 4'd7;
    localparam logic [ADDR_W-1:0] ADR_FLAG   = 4'd8;

    typedef struct packed {
        logic [7:0] sec;
        logic [7:0] min;
        logic [7:0] hr;
        logic [7:0] dd;
    } alarm_set_t;

    typedef struct packed {
        logic [6:0] sec;
        logic [6:0] min;
        logic [6:0] hr;
        logic [2:0] day;
        logic [5:0] date;
    } now_t;

    typedef struct packed {
        logic [1:0]         rate;
        logic               irq_mode;
        logic [NUM_ALM-1:0] ie;
    } ctrl_t;

    typedef struct packed {
        alarm_set_t         a1;
        logic [7:0]         a2_min;
        logic [7:0]         a2_hr;
        logic [7:0]         a2_dd;
        ctrl_t              ctrl;
        logic [NUM_ALM-1:0] flag;
    } regs_t;

    localparam ctrl_t CTRL_RST = '{rate: 2'b11, irq_mode: 1'b1, ie: '0};

    localparam regs_t REGS_RST = '{
        a1:     '0,
        a2_min: 8'h00,
        a2_hr:  8'h00,
        a2_dd:  8'h00,
        ctrl:   CTRL_RST,
        flag:   '0
    };

endpackage

// File: rtl/dalm_regs.sv
module dalm_regs
    import dalm_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [7:0]          wr_data,
    input  logic [NUM_ALM-1:0]  hit,
    output regs_t               regs
);

    regs_t regs_d, regs_q;
    logic [NUM_ALM-1:0] clr_mask;

    always_comb begin
        regs_d   = regs_q;
        clr_mask = '0;
        if (wr_en) begin
            case (wr_addr)
                ADR_A1_SEC: regs_d.a1.sec = wr_data;
                ADR_A1_MIN: regs_d.a1.min = wr_data;
                ADR_A1_HR:  regs_d.a1.hr  = wr_data;
                ADR_A1_DD:  regs_d.a1.dd  = wr_data;
                ADR_A2_MIN: regs_d.a2_min = wr_data;
                ADR_A2_HR:  regs_d.a2_hr  = wr_data;
                ADR_A2_DD:  regs_d.a2_dd  = wr_data;
                ADR_CTRL: begin
                    regs_d.ctrl.rate     = wr_data[4:3];
                    regs_d.ctrl.irq_mode = wr_data[2];
                    regs_d.ctrl.ie       = wr_data[NUM_ALM-1:0];
                end
                ADR_FLAG:   clr_mask = ~wr_data[NUM_ALM-1:0];
                default: ;
            endcase
        end
        // A fresh hit outranks a clear landing in the same cycle
        regs_d.flag = (regs_q.flag & ~clr_mask) | hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= REGS_RST;
        else        regs_q <= regs_d;
    end

    assign regs = regs_q;

endmodule

// File: rtl/dalm_match.sv
module dalm_match
    import dalm_pkg::*;
(
    input  logic       tick,
    input  alarm_set_t alm,
    input  now_t       now,
    output logic       hit
);

    logic       sec_ok, min_ok, hr_ok, dd_ok;
    logic [5:0] dd_target;

    always_comb begin
        dd_target = alm.dd[DYDT_BIT] ? {3'b000, now.day} : now.date;
        sec_ok = alm.sec[MASK_BIT] || (alm.sec[6:0] == now.sec);
        min_ok = alm.min[MASK_BIT] || (alm.min[6:0] == now.min);
        hr_ok  = alm.hr[MASK_BIT]  || (alm.hr[6:0]  == now.hr);
        dd_ok  = alm.dd[MASK_BIT]  || (alm.dd[5:0]  == dd_target);
        hit    = tick && sec_ok && min_ok && hr_ok && dd_ok;
    end

endmodule

// File: rtl/dalm_sqw.sv
module dalm_sqw #(
    parameter int unsigned REF_HZ = 32768
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ref_tick,
    input  logic       restart,
    input  logic [1:0] rate,
    output logic       wave
);

    localparam int unsigned HALF_SLOW = REF_HZ / 2;
    localparam int unsigned HALF_1K   = REF_HZ / 2048;
    localparam int unsigned HALF_4K   = REF_HZ / 8192;
    localparam int unsigned HALF_8K   = REF_HZ / 16384;
    localparam int unsigned CW        = $clog2(HALF_SLOW + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          wave;
    } sqw_state_t;

    sqw_state_t st_d, st_q;
    logic [CW-1:0] lim;

    always_comb begin
        case (rate)
            2'b00:   lim = CW'(HALF_SLOW - 1);
            2'b01:   lim = CW'(HALF_1K - 1);
            2'b10:   lim = CW'(HALF_4K - 1);
            default: lim = CW'(HALF_8K - 1);
        endcase

        st_d = st_q;
        if (restart) begin
            st_d.cnt  = '0;
            st_d.wave = 1'b1;
        end else if (ref_tick) begin
            if (st_q.cnt == lim) begin
                st_d.cnt  = '0;
                st_d.wave = ~st_q.wave;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{cnt: '0, wave: 1'b1};
        else        st_q <= st_d;
    end

    assign wave = st_q.wave;

endmodule

// File: rtl/dual_alarm_irq.sv
module dual_alarm_irq
    import dalm_pkg::*;
#(
    parameter int unsigned REF_HZ = 32768
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sec_tick,
    input  logic [6:0]         now_sec,
    input  logic [6:0]         now_min,
    input  logic [6:0]         now_hour,
    input  logic [2:0]         now_day,
    input  logic [5:0]         now_date,
    input  logic               ref_tick,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [7:0]         wr_data,
    output logic [NUM_ALM-1:0] alm_flag,
    output logic               irq_sqw_n
);

    now_t               now;
    regs_t              regs_q;
    alarm_set_t         alm [NUM_ALM];
    logic [NUM_ALM-1:0] hit;
    logic               ctrl_wr;
    logic               sqw_wave;
    logic               irq_active;

    assign now = '{sec: now_sec, min: now_min, hr: now_hour,
                   day: now_day, date: now_date};

    dalm_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .hit     (hit),
        .regs    (regs_q)
    );

    // Alarm 2 has no seconds byte: it is pinned to an unmasked 00
    assign alm[0] = regs_q.a1;
    assign alm[1] = '{sec: 8'h00, min: regs_q.a2_min,
                      hr: regs_q.a2_hr, dd: regs_q.a2_dd};

    for (genvar gi = 0; gi < NUM_ALM; gi++) begin : g_alm
        dalm_match u_match (
            .tick (sec_tick),
            .alm  (alm[gi]),
            .now  (now),
            .hit  (hit[gi])
        );
    end

    assign ctrl_wr = wr_en && (wr_addr == ADR_CTRL);

    dalm_sqw #(.REF_HZ(REF_HZ)) u_sqw (
        .clk      (clk),
        .rst_n    (rst_n),
        .ref_tick (ref_tick),
        .restart  (ctrl_wr),
        .rate     (regs_q.ctrl.rate),
        .wave     (sqw_wave)
    );

    assign irq_active = |(regs_q.flag & regs_q.ctrl.ie);
    assign irq_sqw_n  = regs_q.ctrl.irq_mode ? ~irq_active : sqw_wave;
    assign alm_flag   = regs_q.flag;

endmodule

// File: rtl/dalm_chk.sv
module dalm_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] hit,
    input logic [1:0] flag,
    input logic [1:0] flag_clr,
    input logic       ref_tick,
    input logic       ctrl_wr,
    input logic       wave
);

    a_r7_hit_sets_a1: assert property (@(posedge clk) disable iff (!rst_n)
        hit[0] |=> flag[0]);

    a_r7_hit_sets_a2: assert property (@(posedge clk) disable iff (!rst_n)
        hit[1] |=> flag[1]);

    a_r5_rise_needs_hit_a1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag[0]) |-> $past(hit[0]));

    a_r5_rise_needs_hit_a2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag[1]) |-> $past(hit[1]));

    a_r6_sticky_a1: assert property (@(posedge clk) disable iff (!rst_n)
        (flag[0] && !flag_clr[0]) |=> flag[0]);

    a_r6_sticky_a2: assert property (@(posedge clk) disable iff (!rst_n)
        (flag[1] && !flag_clr[1]) |=> flag[1]);

    a_r10_wave_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!ref_tick && !ctrl_wr) |=> $stable(wave));

    a_r11_restart_high: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr |=> wave);

endmodule

bind dual_alarm_irq dalm_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .hit      (hit),
    .flag     (alm_flag),
    .flag_clr ({2{wr_en && (wr_addr == dalm_pkg::ADR_FLAG)}} & ~wr_data[1:0]),
    .ref_tick (ref_tick),
    .ctrl_wr  (ctrl_wr),
    .wave     (sqw_wave)
);

// File: tb/sim_dual_alarm_irq.sv
module sim_dual_alarm_irq;

    localparam int CLK_PERIOD = 10;
    localparam int REF_HZ     = 32768;
    localparam int WATCHDOG   = 200000;
    localparam int N_RAND     = 150;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sec_tick = 1'b0;
    logic       ref_tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [3:0] wr_addr = 4'd0;
    logic [7:0] wr_data = 8'd0;
    logic [6:0] now_sec = 7'h00;
    logic [6:0] now_min = 7'h00;
    logic [6:0] now_hour = 7'h00;
    logic [2:0] now_day = 3'd1;
    logic [5:0] now_date = 6'h01;
    logic [1:0] alm_flag;
    logic       irq_sqw_n;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    logic [7:0] m_a1 [4];
    logic [7:0] m_a2 [3];
    logic [1:0] m_flag = 2'b00;
    logic [1:0] m_ie = 2'b00;
    logic       m_mode = 1'b1;

    always #(CLK_PERIOD/2) clk = ~clk;

    dual_alarm_irq #(.REF_HZ(REF_HZ)) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .sec_tick  (sec_tick),
        .now_sec   (now_sec),
        .now_min   (now_min),
        .now_hour  (now_hour),
        .now_day   (now_day),
        .now_date  (now_date),
        .ref_tick  (ref_tick),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .alm_flag  (alm_flag),
        .irq_sqw_n (irq_sqw_n)
    );

    function automatic logic [7:0] bcd(input int unsigned v);
        return 8'(((v / 10) << 4) | (v % 10));
    endfunction

    function automatic logic fld_ok(input logic [7:0] a, input logic [6:0] t);
        return a[7] || (a[6:0] == t);
    endfunction

    function automatic logic dd_ok(input logic [7:0] a);
        if (a[7]) return 1'b1;
        if (a[6]) return a[5:0] == {3'b000, now_day};
        return a[5:0] == now_date;
    endfunction

    function automatic logic [1:0] model_hits();
        logic h1, h2;
        h1 = fld_ok(m_a1[0], now_sec) && fld_ok(m_a1[1], now_min) &&
             fld_ok(m_a1[2], now_hour) && dd_ok(m_a1[3]);
        h2 = (now_sec == 7'h00) && fld_ok(m_a2[0], now_min) &&
             fld_ok(m_a2[1], now_hour) && dd_ok(m_a2[2]);
        return {h2, h1};
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic shadow(input logic [3:0] a, input logic [7:0] d);
        case (a)
            4'd0, 4'd1, 4'd2, 4'd3: m_a1[a[1:0]] = d;
            4'd4: m_a2[0] = d;
            4'd5: m_a2[1] = d;
            4'd6: m_a2[2] = d;
            4'd7: begin m_mode = d[2]; m_ie = d[1:0]; end
            4'd8: m_flag = m_flag & d[1:0];
            default: ;
        endcase
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        shadow(a, d);
    endtask

    task automatic set_time(input logic [6:0] s, input logic [6:0] m,
                            input logic [6:0] h, input logic [2:0] dy,
                            input logic [5:0] dt);
        now_sec = s; now_min = m; now_hour = h; now_day = dy; now_date = dt;
    endtask

    task automatic tick();
        logic [1:0] h;
        h = model_hits();
        sec_tick = 1'b1;
        @(negedge clk);
        sec_tick = 1'b0;
        m_flag = m_flag | h;
    endtask

    task automatic tick_and_clear(input logic [1:0] keep);
        logic [1:0] h;
        h = model_hits();
        sec_tick = 1'b1;
        wr_en = 1'b1; wr_addr = 4'd8; wr_data = {6'b0, keep};
        @(negedge clk);
        sec_tick = 1'b0;
        wr_en = 1'b0;
        m_flag = (m_flag & keep) | h;
    endtask

    task automatic chk_state(input string tag);
        check({tag, " flags"}, int'(alm_flag), int'(m_flag));
        if (m_mode)
            check({tag, " pin"}, int'(irq_sqw_n), int'(!(|(m_flag & m_ie))));
    endtask

    task automatic measure(input string tag, input int exp_half);
        int n;
        n = 0;
        while (irq_sqw_n === 1'b1 && n < 70000) begin n++; @(negedge clk); end
        check({tag, " high half"}, n, exp_half);
        n = 0;
        while (irq_sqw_n === 1'b0 && n < 70000) begin n++; @(negedge clk); end
        check({tag, " low half"}, n, exp_half);
    endtask

    initial begin
        #(CLK_PERIOD * WATCHDOG);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog (all requirements) actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        for (int i = 0; i < 4; i++) m_a1[i] = 8'h00;
        for (int i = 0; i < 3; i++) m_a2[i] = 8'h00;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check("R1 flags after reset", int'(alm_flag), 0);
        check("R1 pin after reset", int'(irq_sqw_n), 1);

        // R2/R8: all-masked alarm 1 hits each strobe; R1: enables off keep pin high
        set_time(7'h30, 7'h45, 7'h12, 3'd3, 6'h15);
        wr(4'd0, 8'h80); wr(4'd1, 8'h80); wr(4'd2, 8'h80); wr(4'd3, 8'h80);
        tick();
        chk_state("R2 all masked");
        check("R1 enables off pin high", int'(irq_sqw_n), 1);

        // R9: enables drive the pin in interrupt mode
        wr(4'd7, 8'b0001_1101);
        check("R9 enabled flag pulls pin low", int'(irq_sqw_n), 0);
        wr(4'd7, 8'b0001_1110);
        check("R9 other enable leaves pin high", int'(irq_sqw_n), 1);

        // R6: write-one has no effect, write-zero clears
        wr(4'd8, 8'h03);
        chk_state("R6 write one keeps");
        check("R6 flag0 still set", int'(alm_flag[0]), 1);
        wr(4'd8, 8'h02);
        chk_state("R6 write zero clears");

        // R5: matching time without strobe sets nothing
        wr(4'd0, 8'h30); wr(4'd1, 8'h45); wr(4'd2, 8'h12); wr(4'd3, 8'h15);
        repeat (5) @(negedge clk);
        chk_state("R5 no strobe");
        tick();
        chk_state("R2 full date match");
        check("R2 flag0 set", int'(alm_flag[0]), 1);

        wr(4'd8, 8'h00);
        set_time(7'h31, 7'h45, 7'h12, 3'd3, 6'h15);
        tick();
        chk_state("R2 seconds mismatch");
        wr(4'd0, 8'h80);
        tick();
        chk_state("R2 seconds masked");

        // R4: day versus date selection
        wr(4'd8, 8'h00);
        wr(4'd0, 8'h31);
        wr(4'd3, 8'h43);
        tick();
        chk_state("R4 day of week match");
        wr(4'd8, 8'h00);
        wr(4'd3, 8'h03);
        tick();
        chk_state("R4 date 03 no match");
        wr(4'd3, 8'h15);
        tick();
        chk_state("R4 date 15 match");

        // R3: alarm 2 all masked fires at second 00 only
        wr(4'd8, 8'h00);
        wr(4'd4, 8'h80); wr(4'd5, 8'h80); wr(4'd6, 8'h80);
        set_time(7'h00, 7'h46, 7'h12, 3'd3, 6'h15);
        tick();
        chk_state("R3 second 00");
        check("R3 flag1 set", int'(alm_flag[1]), 1);
        wr(4'd8, 8'h00);
        set_time(7'h01, 7'h46, 7'h12, 3'd3, 6'h15);
        tick();
        chk_state("R3 second 01");

        // R7: clear and hit in the same cycle
        set_time(7'h00, 7'h47, 7'h12, 3'd3, 6'h15);
        tick();
        tick_and_clear(2'b00);
        chk_state("R7 hit beats clear");
        check("R7 flag1 kept", int'(alm_flag[1]), 1);

        // R8: flags set in square-wave mode too
        wr(4'd8, 8'h00);
        wr(4'd7, 8'b0001_1000);
        tick();
        chk_state("R8 flag in wave mode");
        check("R8 flag1 set in wave mode", int'(alm_flag[1]), 1);
        wr(4'd7, 8'b0001_1100);

        // R2 R3 R4 R9: constrained random
        for (int it = 0; it < N_RAND; it++) begin
            logic [6:0] s, m, h;
            logic [2:0] dy;
            logic [5:0] dt;
            int unsigned k1, k2;
            logic dydt;
            logic [5:0] v6;
            s  = ($urandom_range(0, 3) == 0) ? 7'h00 : 7'(bcd($urandom_range(0, 59)));
            m  = 7'(bcd($urandom_range(0, 59)));
            h  = 7'(bcd($urandom_range(0, 23)));
            dy = 3'($urandom_range(1, 7));
            dt = 6'(bcd($urandom_range(1, 31)));
            k1 = $urandom_range(0, 4);
            k2 = $urandom_range(0, 3);
            wr(4'd0, {k1 > 0, $urandom_range(0, 1) ? s : 7'(bcd($urandom_range(0, 59)))});
            wr(4'd1, {k1 > 1, $urandom_range(0, 1) ? m : 7'(bcd($urandom_range(0, 59)))});
            wr(4'd2, {k1 > 2, $urandom_range(0, 1) ? h : 7'(bcd($urandom_range(0, 23)))});
            dydt = 1'($urandom_range(0, 1));
            if ($urandom_range(0, 1)) v6 = dydt ? {3'b000, dy} : dt;
            else v6 = dydt ? 6'($urandom_range(1, 7)) : 6'(bcd($urandom_range(1, 31)));
            wr(4'd3, {k1 > 3, dydt, v6});
            wr(4'd4, {k2 > 0, $urandom_range(0, 1) ? m : 7'(bcd($urandom_range(0, 59)))});
            wr(4'd5, {k2 > 1, $urandom_range(0, 1) ? h : 7'(bcd($urandom_range(0, 23)))});
            dydt = 1'($urandom_range(0, 1));
            if ($urandom_range(0, 1)) v6 = dydt ? {3'b000, dy} : dt;
            else v6 = dydt ? 6'($urandom_range(1, 7)) : 6'(bcd($urandom_range(1, 31)));
            wr(4'd6, {k2 > 2, dydt, v6});
            wr(4'd7, {3'b000, 2'b11, 1'b1, 2'($urandom_range(0, 3))});
            wr(4'd8, 8'h00);
            set_time(s, m, h, dy, dt);
            tick();
            chk_state("R2 R3 R4 R9 random");
        end

        // R10 R11: square wave rates and restart
        ref_tick = 1'b0;
        wr(4'd7, 8'b0001_1000);
        repeat (20) @(negedge clk);
        check("R10 no reference steps keeps wave high", int'(irq_sqw_n), 1);
        ref_tick = 1'b1;
        wr(4'd7, 8'b0001_1000);
        measure("R10 rate 11", REF_HZ / 16384);
        wr(4'd7, 8'b0001_0000);
        measure("R10 rate 10", REF_HZ / 8192);
        wr(4'd7, 8'b0000_1000);
        measure("R10 rate 01", REF_HZ / 2048);
        wr(4'd7, 8'b0000_1000);
        repeat (5) @(negedge clk);
        wr(4'd7, 8'b0000_1000);
        measure("R11 restart mid wave", REF_HZ / 2048);
        wr(4'd7, 8'b0000_0000);
        measure("R10 rate 00", REF_HZ / 2);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule